// File: doc/BRIEF.md
# SDRAM Data Path with Byte Masks

This block is the controller-side data path for a 16-bit single-data-rate SDRAM. A command sequencer tells it, one cycle ahead of the command reaching the pins, that a read, write, burst stop or precharge is being issued. Every output is registered, so the values it produces line up with the command pin cycle. A write beat is launched on the DQ bus in the same pin cycle as its column command, because write latency is zero. A read beat is captured a programmable number of cycles later, set by the CAS latency. The burst length and the CAS latency come from the sequencer as codes. Both must be changed only while no burst is in flight.

A pipeline of CAS-latency depth marks the cycles in which read data is due on the bus. The same pipeline produces the capture strobe. It also blocks the output enable, so the controller never drives DQ while the memory may be driving it. The two byte-mask pins follow the mask requests. The block records their history so that each captured read beat knows which bytes the memory left undriven. A masked write byte is masked in its own cycle, while a masked read byte is masked two cycles after the mask pin is high. A stop or precharge ends issue of new read beats, but beats already issued still arrive. In every requirement, mask bit 0 covers DQ[7:0] and bit 1 covers DQ[15:8].

Top module: `sdr_dq_path`

## Requirements
- R1: While reset is high and in the first cycle after it, dq_oe_o, dq_o, dm_o, rd_valid_o, rd_data_o and rd_byte_en_o are all zero, whatever mask request is applied.
- R2: A write strobe sampled at edge s makes dq_oe_o high after edges s .. s+L-1, for a burst of L beats. In each of those cycles, dq_o carries the wr_data_i sampled at that edge. After edge s+L, dq_oe_o is low and dq_o is zero.
- R3: In every write-beat cycle, dm_o equals the mask_req_i sampled at the same edge as the beat's data, so the mask acts in the beat's own cycle.
- R4: A read strobe sampled at edge s with CAS latency C captures beat k at edge s+C+1+k. That capture takes dq_i as driven during the preceding cycle. rd_valid_o is high in the cycle after that edge, and is low in cycles that carry no beat.
- R5: A captured read byte b is forced to zero, and rd_byte_en_o[b] is low, when dm_o[b] was high three cycles before rd_valid_o. That is two cycles before the data was on DQ. Otherwise rd_byte_en_o[b] is high during a valid beat. Both enables are zero when rd_valid_o is low.
- R6: Burst length code 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Code 7 gives a burst that runs until it is terminated. Any other code gives 1 beat.
- R7: A stop or precharge strobe sampled at edge t during a read burst stops new read beats from that edge on. Beats issued before t are still captured, and the last one is valid after edge t+C.
- R8: A stop, precharge or read strobe sampled at edge t during a write burst drops dq_oe_o after edge t.
- R9: dq_oe_o is never high in a cycle in which read data is due on DQ. A write beat that falls in such a cycle is not driven, and dm_o is all ones in that cycle.
- R10: CAS latency codes 1, 2 and 3 select that latency, and code 0 acts as latency 1.
- R11: A read strobe that arrives during a read burst ends the old burst and starts a new burst of full length at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd_i | input | 1 | Write column command issued next cycle |
| rd_cmd_i | input | 1 | Read column command issued next cycle |
| stop_cmd_i | input | 1 | Burst stop command issued next cycle |
| pre_cmd_i | input | 1 | Precharge of the bursting bank issued next cycle |
| bl_code_i | input | 3 | Burst length code (R6) |
| cl_code_i | input | 2 | CAS latency code (R10) |
| wr_data_i | input | 16 | Write data for the beat launched next cycle |
| mask_req_i | input | 2 | Byte mask request for the next pin cycle |
| dq_i | input | 16 | Data from the DQ pads |
| dq_o | output | 16 | Data to the DQ pads |
| dq_oe_o | output | 1 | DQ output enable |
| dm_o | output | 2 | Byte mask pins, bit 0 lower byte |
| rd_data_o | output | 16 | Captured read beat, masked bytes zero |
| rd_valid_o | output | 1 | Captured read beat is valid |
| rd_byte_en_o | output | 2 | Bytes of the captured beat that the memory drove |

## Verification
The checker watches four timing relations on every cycle: the output enable never overlaps a cycle in which read data is due, the driven write data and mask match the requests one edge earlier, every due cycle is followed by a capture, and the byte enables of a captured beat are the inverse of the mask pins three cycles earlier. Burst lengths, the reserved length and latency codes, and the cut-off points after a stop, precharge or second read are shown only by the bench's scenarios. The same holds for a write that collides with read data, because whether those are correct depends on counting beats across a whole burst.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  localparam logic [2:0] BL_RUN_TO_STOP = 3'd7;

  // Beat count of a burst length code; reserved codes fall back to one beat.
  function automatic int unsigned burst_beats(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic runs_to_stop(input logic [2:0] code);
    return code == BL_RUN_TO_STOP;
  endfunction

endpackage

// File: rtl/sdr_burst_track.sv
module sdr_burst_track
  import sdr_dp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       term,
  input  logic [2:0] bl_code,
  output logic       issue
);

  logic             active_q;
  logic             open_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] first_left;

  always_comb first_left = CNT_W'(burst_beats(bl_code) - 1);

  // A new command wins over a terminator in the same cycle.
  assign issue = start | (active_q & ~term);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      open_q   <= 1'b0;
      left_q   <= '0;
    end else if (start) begin
      open_q   <= runs_to_stop(bl_code);
      left_q   <= first_left;
      active_q <= runs_to_stop(bl_code) | (first_left != '0);
    end else if (active_q) begin
      if (term) begin
        active_q <= 1'b0;
      end else if (!open_q) begin
        left_q   <= left_q - 1'b1;
        active_q <= (left_q != CNT_W'(1));
      end
    end
  end

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter  int DQ_W   = 16,
  parameter  int BYTE_W = 8,
  parameter  int MAX_CL = 3,
  localparam int NB     = DQ_W / BYTE_W,
  localparam int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [CL_W-1:0] cl,
  input  logic [DQ_W-1:0] dq_i,
  input  logic [NB-1:0]   dm_pin,
  output logic            due_now,
  output logic            due_next,
  output logic [DQ_W-1:0] rd_data_o,
  output logic            rd_valid_o,
  output logic [NB-1:0]   rd_byte_en_o
);

  localparam int DEPTH = 1 << CL_W;

  // Bit k is set in the (k+1)-th cycle after a beat left the column stage.
  logic [DEPTH-1:0] due_sr;
  logic [NB-1:0]    dm_d1;
  logic [NB-1:0]    dm_d2;

  assign due_now  = due_sr[cl];
  assign due_next = due_sr[cl - 1'b1];

  always_ff @(posedge clk) begin
    if (rst) begin
      due_sr     <= '0;
      dm_d1      <= '0;
      dm_d2      <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      due_sr     <= {due_sr[DEPTH-2:0], issue};
      dm_d1      <= dm_pin;
      dm_d2      <= dm_d1;
      rd_valid_o <= due_now;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    logic              en_q;
    logic              take;

    assign take = due_now & ~dm_d2[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '0;
        en_q   <= 1'b0;
      end else begin
        en_q   <= take;
        byte_q <= take ? dq_i[b*BYTE_W +: BYTE_W] : '0;
      end
    end

    assign rd_data_o[b*BYTE_W +: BYTE_W] = byte_q;
    assign rd_byte_en_o[b]               = en_q;
  end

endmodule

// File: rtl/sdr_dq_path.sv
module sdr_dq_path
  import sdr_dp_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int BYTE_W    = 8,
  parameter int MAX_CL    = 3,
  parameter int MAX_BURST = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_cmd_i,
  input  logic                              rd_cmd_i,
  input  logic                              stop_cmd_i,
  input  logic                              pre_cmd_i,
  input  logic [2:0]                        bl_code_i,
  input  logic [$clog2(MAX_CL+1)-1:0]       cl_code_i,
  input  logic [DQ_W-1:0]                   wr_data_i,
  input  logic [DQ_W/BYTE_W-1:0]            mask_req_i,
  input  logic [DQ_W-1:0]                   dq_i,
  output logic [DQ_W-1:0]                   dq_o,
  output logic                              dq_oe_o,
  output logic [DQ_W/BYTE_W-1:0]            dm_o,
  output logic [DQ_W-1:0]                   rd_data_o,
  output logic                              rd_valid_o,
  output logic [DQ_W/BYTE_W-1:0]            rd_byte_en_o
);

  localparam int NB    = DQ_W / BYTE_W;
  localparam int CL_W  = $clog2(MAX_CL + 1);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic [CL_W-1:0] cl_eff;
  logic            rd_issue;
  logic            wr_issue;
  logic            rd_due;
  logic            rd_due_nxt;
  logic            wr_drive;
  logic            wr_clash;

  always_comb cl_eff = (cl_code_i == '0) ? CL_W'(1) : cl_code_i;

  sdr_burst_track #(.CNT_W(CNT_W)) u_rd_burst (
    .clk     (clk),
    .rst     (rst),
    .start   (rd_cmd_i),
    .term    (stop_cmd_i | pre_cmd_i | wr_cmd_i),
    .bl_code (bl_code_i),
    .issue   (rd_issue)
  );

  sdr_burst_track #(.CNT_W(CNT_W)) u_wr_burst (
    .clk     (clk),
    .rst     (rst),
    .start   (wr_cmd_i),
    .term    (stop_cmd_i | pre_cmd_i | rd_cmd_i),
    .bl_code (bl_code_i),
    .issue   (wr_issue)
  );

  sdr_rd_capture #(.DQ_W(DQ_W), .BYTE_W(BYTE_W), .MAX_CL(MAX_CL)) u_rd_cap (
    .clk          (clk),
    .rst          (rst),
    .issue        (rd_issue),
    .cl           (cl_eff),
    .dq_i         (dq_i),
    .dm_pin       (dm_o),
    .due_now      (rd_due),
    .due_next     (rd_due_nxt),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .rd_byte_en_o (rd_byte_en_o)
  );

  // A write beat landing on a cycle owned by read data is dropped and masked.
  assign wr_drive = wr_issue & ~rd_due_nxt;
  assign wr_clash = wr_issue & rd_due_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe_o <= 1'b0;
      dq_o    <= '0;
      dm_o    <= '0;
    end else begin
      dq_oe_o <= wr_drive;
      dq_o    <= wr_drive ? wr_data_i : '0;
      dm_o    <= wr_clash ? {NB{1'b1}} : mask_req_i;
    end
  end

endmodule

// File: rtl/sdr_dq_path_chk.sv
module sdr_dq_path_chk #(
  parameter int DQ_W = 16,
  parameter int NB   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            dq_oe_o,
  input logic [DQ_W-1:0] dq_o,
  input logic [DQ_W-1:0] wr_data_i,
  input logic [NB-1:0]   dm_o,
  input logic [NB-1:0]   mask_req_i,
  input logic [NB-1:0]   rd_byte_en_o,
  input logic            rd_valid_o,
  input logic            rd_due
);

  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe_o && rd_due));

  a_r2_write_data: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> dq_o == $past(wr_data_i));

  a_r3_write_mask: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> dm_o == $past(mask_req_i));

  a_r4_capture_follows_due: assert property (@(posedge clk) disable iff (rst)
    rd_due |=> rd_valid_o);

  a_r5_read_mask_delay: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> rd_byte_en_o == ~$past(dm_o, 3));

endmodule

bind sdr_dq_path sdr_dq_path_chk #(.DQ_W(DQ_W), .NB(DQ_W/BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dq_oe_o      (dq_oe_o),
  .dq_o         (dq_o),
  .wr_data_i    (wr_data_i),
  .dm_o         (dm_o),
  .mask_req_i   (mask_req_i),
  .rd_byte_en_o (rd_byte_en_o),
  .rd_valid_o   (rd_valid_o),
  .rd_due       (rd_due)
);

// File: tb/sim_sdr_dq_path.sv
`timescale 1ns/1ps
module sim_sdr_dq_path;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_cmd_i, rd_cmd_i, stop_cmd_i, pre_cmd_i;
  logic [2:0]  bl_code_i;
  logic [1:0]  cl_code_i;
  logic [15:0] wr_data_i, dq_i, dq_o, rd_data_o;
  logic [1:0]  mask_req_i, dm_o, rd_byte_en_o;
  logic        dq_oe_o, rd_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sdr_dq_path u0 (
    .clk(clk), .rst(rst), .wr_cmd_i(wr_cmd_i), .rd_cmd_i(rd_cmd_i),
    .stop_cmd_i(stop_cmd_i), .pre_cmd_i(pre_cmd_i), .bl_code_i(bl_code_i),
    .cl_code_i(cl_code_i), .wr_data_i(wr_data_i), .mask_req_i(mask_req_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dm_o(dm_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_byte_en_o(rd_byte_en_o)
  );

  // {write, bl code, cl code, mask for beat 1}
  localparam logic [7:0] VEC [0:7] = '{
    8'b0_010_10_01, 8'b0_011_11_10, 8'b0_000_01_11, 8'b0_001_00_01,
    8'b0_100_10_10, 8'b1_010_10_01, 8'b1_011_01_10, 8'b1_001_11_11
  };

  function automatic int beats_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : int'(c);
  endfunction

  function automatic logic [15:0] pat(input int r, input int k);
    return 16'(((r + 1) << 12) | 16'h0A00 | ((k * 17) & 8'hFF));
  endfunction

  function automatic logic [15:0] apply_mask(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? 8'h00 : d[15:8], m[0] ? 8'h00 : d[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_idle();
    wr_cmd_i = 0; rd_cmd_i = 0; stop_cmd_i = 0; pre_cmd_i = 0;
    wr_data_i = '0; dq_i = '0; mask_req_i = '0;
  endtask

  task automatic run_dir(input int rd0, input int rd1, input int wr0, input int st,
                         input int pr, input logic [2:0] bl, input logic [1:0] clc,
                         output int vcnt, output int vlast, output int ocnt,
                         output logic [31:0] oe_tr, output logic [31:0] dm1_tr);
    bl_code_i = bl; cl_code_i = clc;
    vcnt = 0; vlast = -1; ocnt = 0; oe_tr = '0; dm1_tr = '0;
    for (int cyc = 0; cyc < 24; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        if (rd_valid_o) begin vcnt++; vlast = cyc - 1; end
        if (dq_oe_o) begin ocnt++; oe_tr[cyc-1] = 1'b1; end
        if (dm_o == 2'b11) dm1_tr[cyc-1] = 1'b1;
      end
      rd_cmd_i   = (cyc == rd0) || (cyc == rd1);
      wr_cmd_i   = (cyc == wr0);
      stop_cmd_i = (cyc == st);
      pre_cmd_i  = (cyc == pr);
      wr_data_i  = 16'hC000 | 16'(cyc);
      dq_i       = 16'h3300 | 16'(cyc);
      mask_req_i = '0;
    end
    set_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int vc, vl, oc;
    logic [31:0] otr, dtr;
    logic [7:0] v;
    bit w;
    logic [2:0] bl;
    logic [1:0] clc, m, mk;
    int len, lat, nc, e, k;
    string tag;

    set_idle();
    bl_code_i = 3'd0; cl_code_i = 2'd1;
    rst = 1'b1;
    mask_req_i = 2'b11;
    repeat (3) @(negedge clk);
    check(dm_o == 2'b00 && dq_oe_o == 1'b0 && rd_valid_o == 1'b0, "R1", "outputs in reset",
          {dm_o, dq_oe_o, rd_valid_o}, 0);
    rst = 1'b0;
    mask_req_i = '0;
    check(dq_o == '0 && rd_data_o == '0 && rd_byte_en_o == '0, "R1", "data after reset",
          {dq_o, rd_data_o, rd_byte_en_o}, 0);
    repeat (2) @(negedge clk);

    // Vector table: one burst per row, checked beat by beat.
    for (int r = 0; r < 8; r++) begin
      v = VEC[r]; w = v[7]; bl = v[6:4]; clc = v[3:2]; m = v[1:0];
      len = beats_of(bl); lat = lat_of(clc); nc = len + lat + 4;
      tag = w ? "R2" : (clc == 2'd0 ? "R10" : (bl > 3'd3 ? "R6" : "R4"));
      bl_code_i = bl; cl_code_i = clc;
      for (int cyc = 0; cyc < nc; cyc++) begin
        @(negedge clk);
        if (cyc > 0) begin
          e = cyc - 1;
          if (w) begin
            check(dq_oe_o == (e < len), tag, "write enable", dq_oe_o, (e < len));
            if (e < len) begin
              check(dq_o == pat(r, e), "R2", "write data", dq_o, pat(r, e));
              check(dm_o == ((e == 1) ? m : 2'b00), "R3", "write mask", dm_o,
                    (e == 1) ? m : 2'b00);
            end
          end else begin
            k = e - lat - 1;
            check(rd_valid_o == (k >= 0 && k < len), tag, "read valid", rd_valid_o,
                  (k >= 0 && k < len));
            if (k >= 0 && k < len) begin
              mk = (k == 1) ? m : 2'b00;
              check(rd_data_o == apply_mask(pat(r, k), mk), "R5", "read data", rd_data_o,
                    apply_mask(pat(r, k), mk));
              check(rd_byte_en_o == ~mk, "R5", "byte enables", rd_byte_en_o, ~mk);
            end
          end
        end
        wr_cmd_i   = w && (cyc == 0);
        rd_cmd_i   = !w && (cyc == 0);
        wr_data_i  = (w && cyc < len) ? pat(r, cyc) : 16'h0;
        mask_req_i = w ? ((cyc == 1) ? m : 2'b00) : ((cyc == lat - 1) ? m : 2'b00);
        k = cyc - lat - 1;
        dq_i       = (!w && k >= 0 && k < len) ? pat(r, k) : 16'h0;
      end
      set_idle();
      repeat (3) @(negedge clk);
    end

    // R7 with R6: open-ended read cut by burst stop at edge 3, latency 2.
    run_dir(0, -1, -1, 3, -1, 3'd7, 2'd2, vc, vl, oc, otr, dtr);
    check(vc == 3, "R7", "beats after stop", vc, 3);
    check(vl == 5, "R7", "last beat after stop", vl, 5);

    // R7: 8-beat read cut by precharge at edge 2, latency 3.
    run_dir(0, -1, -1, -1, 2, 3'd3, 2'd3, vc, vl, oc, otr, dtr);
    check(vc == 2, "R7", "beats after precharge", vc, 2);
    check(vl == 5, "R7", "last beat after precharge", vl, 5);

    // R8: 8-beat write cut by precharge at edge 3.
    run_dir(-1, -1, 0, -1, 3, 3'd3, 2'd1, vc, vl, oc, otr, dtr);
    check(oc == 3, "R8", "write beats before precharge", oc, 3);
    check(otr[3] == 1'b0, "R8", "enable after precharge", otr[3], 0);

    // R8: 4-beat write cut by a read at edge 2, which then runs in full.
    run_dir(2, -1, 0, -1, -1, 3'd2, 2'd3, vc, vl, oc, otr, dtr);
    check(oc == 2, "R8", "write beats before read", oc, 2);
    check(vc == 4, "R8", "read after write", vc, 4);

    // R11: second read at edge 2 restarts a 4-beat burst, latency 1.
    run_dir(0, 2, -1, -1, -1, 3'd2, 2'd1, vc, vl, oc, otr, dtr);
    check(vc == 6, "R11", "beats with restart", vc, 6);
    check(vl == 7, "R11", "last restarted beat", vl, 7);

    // R6: open-ended write runs until burst stop at edge 12.
    run_dir(-1, -1, 0, 12, -1, 3'd7, 2'd1, vc, vl, oc, otr, dtr);
    check(oc == 12, "R6", "open-ended write beats", oc, 12);

    // R9: one-beat write lands on the cycle of read data (latency 3).
    run_dir(0, -1, 3, -1, -1, 3'd0, 2'd3, vc, vl, oc, otr, dtr);
    check(oc == 0, "R9", "colliding beat driven", oc, 0);
    check(dtr[3] == 1'b1, "R9", "mask during collision", dtr[3], 1);
    check(vc == 1 && vl == 4, "R9", "read beat kept", vl, 4);

    // R1: reset in the middle of a write burst.
    bl_code_i = 3'd3;
    @(negedge clk); wr_cmd_i = 1'b1; wr_data_i = 16'h5A5A;
    @(negedge clk); wr_cmd_i = 1'b0;
    @(negedge clk);
    check(dq_oe_o == 1'b1, "R2", "enable before reset", dq_oe_o, 1);
    rst = 1'b1;
    @(negedge clk);
    check(dq_oe_o == 1'b0 && dq_o == '0, "R1", "reset mid-burst", dq_oe_o, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(dq_oe_o == 1'b0, "R1", "no resume after reset", dq_oe_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule